// File: doc/BRIEF.md
# Deferred Interrupt Delivery Controller

This block sits in the execute stage of a pipelined processor. For each incoming instruction it decides whether an interrupt is taken in place of that instruction. It picks a vector from a synchronous exception request, the decrementer timer or the external interrupt line, and records the vector and a status word for the writeback stage to save.

Older memory operations may still be in flight in the load/store unit when an interrupt is detected. In that case the interrupt is parked in a pending state. The block stalls decode, and the interrupt is delivered once the load/store unit drains. If a memory operation raises its own interrupt first, the parked interrupt is dropped, because the memory fault now owns the machine state.

All outputs are registered. The decision made on the inputs of one cycle appears on the outputs after the next rising clock edge.

Top module: `deferred_irq_ctrl`

## Requirements
- R1: An asynchronous source is eligible only when `irq_en_i` is 1 and at least one of `dec_sign_i` or `ext_irq_i` is 1. With `irq_en_i` low and no synchronous request, no interrupt is raised.
- R2: When both asynchronous sources are active, the decrementer wins and gives vector 0x900. The external line alone gives vector 0x500.
- R3: An interrupt is detected only in a cycle where `insn_vld_i` is 1.
- R4: No interrupt is detected when `insn_second_i` is 1, or while an interrupt is already pending (`busy_o` high).
- R5: A detection made while `ls_busy_i` is 1 parks the interrupt. `busy_o` reads 1 after the next edge and stays 1 while `ls_busy_i` stays 1 and `ls_intr_i` stays 0. `intr_o` stays 0 during that time.
- R6: While an interrupt is pending, `vec_o` and `status_o` keep the values captured at detection, whatever the inputs do.
- R7: `ls_intr_i` high discards any detected or pending interrupt. After the next edge both `busy_o` and `intr_o` read 0.
- R8: After each edge, `intr_o` equals (a detection or a pending interrupt in the previous cycle) AND NOT (`ls_busy_i` OR `ls_intr_i` in that cycle).
- R9: A synchronous request (`exc_req_i`) outranks both asynchronous sources, and its vector `exc_vec_i` is used.
- R10: After reset, `intr_o`, `busy_o`, `vec_o` and `status_o` are all 0.
- R11: When a pending interrupt is delivered, `busy_o` falls on the same edge that `intr_o` rises. `intr_o` and `busy_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_vld_i | input | 1 | Incoming instruction is valid |
| insn_second_i | input | 1 | Incoming instruction is the second half of a split operation |
| irq_en_i | input | 1 | Asynchronous interrupt enable |
| dec_sign_i | input | 1 | Decrementer sign (top) bit |
| ext_irq_i | input | 1 | External interrupt request |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_vec_i | input | VEC_W | Vector of the synchronous exception |
| status_i | input | STAT_W | Status word to save at detection |
| ls_busy_i | input | 1 | Load/store unit holds unfinished older operations |
| ls_intr_i | input | 1 | Load/store unit is raising its own interrupt |
| intr_o | output | 1 | Interrupt to writeback |
| vec_o | output | VEC_W | Interrupt vector |
| status_o | output | STAT_W | Saved status word |
| busy_o | output | 1 | Stall decode: an interrupt is pending |

## Verification
The bench targets the pending window in several ways:
- It changes the sources, the synchronous request and `status_i` while an interrupt is parked. A design that re-evaluates during that window would show a new vector or status word.
- It raises `ls_intr_i` during the window. A design that ignores it would later deliver a stale interrupt on top of the memory fault.
- It drives both timer and external sources together, and pairs a synchronous request with an asynchronous one, to expose a wrong priority.
- It raises the sources with no valid instruction or on a second half. A design that ignores those conditions would raise `intr_o` when it must not.
- It checks that `busy_o` falls on the same edge that `intr_o` rises, so a late release of the stall is caught.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_SYNC = 2'd1,
      SRC_DEC  = 2'd2,
      SRC_EXT  = 2'd3
   } dirq_src_e;
endpackage

// File: rtl/dirq_select.sv
// Source arbitration and vector choice; purely combinational.
module dirq_select
   import dirq_pkg::*;
#(
   parameter int VEC_W     = 12,
   parameter int DEC_VEC   = 'h900,
   parameter int EXT_VEC   = 'h500,
   parameter bit DEC_FIRST = 1'b1
) (
   input  logic             irq_en,
   input  logic             dec_sign,
   input  logic             ext_irq,
   input  logic             exc_req,
   input  logic [VEC_W-1:0] exc_vec,
   output dirq_src_e        src,
   output logic [VEC_W-1:0] vec
);
   localparam logic [VEC_W-1:0] DEC_V = VEC_W'(DEC_VEC);
   localparam logic [VEC_W-1:0] EXT_V = VEC_W'(EXT_VEC);

   logic dec_ok, ext_ok;
   assign dec_ok = irq_en & dec_sign;
   assign ext_ok = irq_en & ext_irq;

   dirq_src_e async_src;

   generate
      if (DEC_FIRST) begin : g_dec_first
         always_comb begin
            if (dec_ok)      async_src = SRC_DEC;
            else if (ext_ok) async_src = SRC_EXT;
            else             async_src = SRC_NONE;
         end
      end else begin : g_ext_first
         always_comb begin
            if (ext_ok)      async_src = SRC_EXT;
            else if (dec_ok) async_src = SRC_DEC;
            else             async_src = SRC_NONE;
         end
      end
   endgenerate

   always_comb begin
      src = exc_req ? SRC_SYNC : async_src;
      unique case (src)
         SRC_SYNC: vec = exc_vec;
         SRC_DEC:  vec = DEC_V;
         SRC_EXT:  vec = EXT_V;
         default:  vec = '0;
      endcase
   end
endmodule

// File: rtl/dirq_defer.sv
// Detection gating, pending state and delivery decision.
module dirq_defer
   import dirq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      insn_vld,
   input  logic      insn_second,
   input  dirq_src_e src,
   input  logic      ls_busy,
   input  logic      ls_intr,
   output logic      detect,
   output logic      intr_q,
   output logic      pend_q
);
   logic want, deliver, pend_d;

   // New evaluation only for a valid first-half instruction with nothing parked.
   assign detect  = insn_vld & ~insn_second & ~pend_q & (src != SRC_NONE);
   assign want    = detect | pend_q;
   assign deliver = want & ~(ls_busy | ls_intr);
   // Park while memory drains; a load/store fault throws it away.
   assign pend_d  = want & ls_busy & ~ls_intr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         intr_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         intr_q <= deliver;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/dirq_hold.sv
// Load-enabled capture register.
module dirq_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/deferred_irq_ctrl.sv
module deferred_irq_ctrl
   import dirq_pkg::*;
#(
   parameter int VEC_W     = 12,
   parameter int STAT_W    = 16,
   parameter int DEC_VEC   = 'h900,
   parameter int EXT_VEC   = 'h500,
   parameter bit DEC_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_vld_i,
   input  logic              insn_second_i,
   input  logic              irq_en_i,
   input  logic              dec_sign_i,
   input  logic              ext_irq_i,
   input  logic              exc_req_i,
   input  logic [VEC_W-1:0]  exc_vec_i,
   input  logic [STAT_W-1:0] status_i,
   input  logic              ls_busy_i,
   input  logic              ls_intr_i,
   output logic              intr_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic [STAT_W-1:0] status_o,
   output logic              busy_o
);
   localparam int CAP_W = VEC_W + STAT_W;

   generate
      if (VEC_W < 1 || STAT_W < 1) begin : g_bad_width
         $error("deferred_irq_ctrl: widths must be positive");
      end
      if (DEC_VEC >= (1 << VEC_W) || EXT_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("deferred_irq_ctrl: fixed vector does not fit VEC_W");
      end
   endgenerate

   dirq_src_e        src;
   logic [VEC_W-1:0] sel_vec;
   logic             detect, pend_q;
   logic [CAP_W-1:0] cap_q;

   dirq_select #(
      .VEC_W(VEC_W), .DEC_VEC(DEC_VEC), .EXT_VEC(EXT_VEC), .DEC_FIRST(DEC_FIRST)
   ) u_sel (
      .irq_en(irq_en_i), .dec_sign(dec_sign_i), .ext_irq(ext_irq_i),
      .exc_req(exc_req_i), .exc_vec(exc_vec_i), .src(src), .vec(sel_vec)
   );

   dirq_defer u_defer (
      .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld_i), .insn_second(insn_second_i),
      .src(src), .ls_busy(ls_busy_i), .ls_intr(ls_intr_i),
      .detect(detect), .intr_q(intr_o), .pend_q(pend_q)
   );

   // Vector and status are captured only at detection; pending blocks detection.
   dirq_hold #(.W(CAP_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .load(detect),
      .d({sel_vec, status_i}), .q(cap_q)
   );

   assign vec_o    = cap_q[CAP_W-1:STAT_W];
   assign status_o = cap_q[STAT_W-1:0];
   assign busy_o   = pend_q;
endmodule

// File: rtl/deferred_irq_chk.sv
module deferred_irq_chk #(
   parameter int VEC_W  = 12,
   parameter int STAT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_vld_i,
   input logic              irq_en_i,
   input logic              exc_req_i,
   input logic              ls_busy_i,
   input logic              ls_intr_i,
   input logic              intr_o,
   input logic [VEC_W-1:0]  vec_o,
   input logic [STAT_W-1:0] status_o,
   input logic              busy_o
);
   assert_no_async_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en_i && !exc_req_i && !busy_o) |=> !intr_o);

   assert_need_valid_insn_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!insn_vld_i && !busy_o) |=> (!intr_o && !busy_o));

   assert_pending_persists_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && ls_busy_i && !ls_intr_i) |=> busy_o);

   assert_capture_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ($stable(vec_o) && $stable(status_o)));

   assert_ls_fault_discards_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ls_intr_i |=> (!intr_o && !busy_o));

   assert_no_deliver_while_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ls_busy_i |=> !intr_o);

   assert_deliver_releases_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      intr_o |-> !busy_o);
endmodule

bind deferred_irq_ctrl deferred_irq_chk #(.VEC_W(VEC_W), .STAT_W(STAT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .insn_vld_i(insn_vld_i), .irq_en_i(irq_en_i),
   .exc_req_i(exc_req_i), .ls_busy_i(ls_busy_i), .ls_intr_i(ls_intr_i),
   .intr_o(intr_o), .vec_o(vec_o), .status_o(status_o), .busy_o(busy_o)
);

// File: tb/sim_deferred_irq_ctrl.sv
`timescale 1ns/1ps
module sim_deferred_irq_ctrl;
   localparam int VW = 12;
   localparam int SW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vld = 0, sec = 0, en = 0, dec = 0, ext = 0, exc = 0, lb = 0, li = 0;
   logic [VW-1:0] evec = '0;
   logic [SW-1:0] st = '0;
   logic intr_o, busy_o;
   logic [VW-1:0] vec_o;
   logic [SW-1:0] status_o;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // model state
   logic m_pend = 0, m_intr = 0;
   logic [VW-1:0] m_vec = '0;
   logic [SW-1:0] m_st = '0;

   always #2.5 clk = ~clk;

   deferred_irq_ctrl #(.VEC_W(VW), .STAT_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .insn_vld_i(vld), .insn_second_i(sec),
      .irq_en_i(en), .dec_sign_i(dec), .ext_irq_i(ext), .exc_req_i(exc),
      .exc_vec_i(evec), .status_i(st), .ls_busy_i(lb), .ls_intr_i(li),
      .intr_o(intr_o), .vec_o(vec_o), .status_o(status_o), .busy_o(busy_o)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [VW-1:0] pick_vec(input logic x, input logic [VW-1:0] xv,
                                               input logic d, input logic e);
      if (x) return xv;          // R9 synchronous first
      if (d) return VW'('h900);  // R2 timer first
      if (e) return VW'('h500);
      return '0;
   endfunction

   // One clock: inputs already driven; advance model and compare after the edge.
   task automatic step();
      logic det, want;
      det  = vld && !sec && !m_pend && (exc || (en && (dec || ext)));
      want = det || m_pend;
      @(posedge clk);
      if (!rst_n) begin
         m_pend = 0; m_intr = 0; m_vec = '0; m_st = '0;
      end else begin
         m_intr = want && !(lb || li);
         m_pend = want && lb && !li;
         if (det) begin
            m_vec = pick_vec(exc, evec, en && dec, en && ext);
            m_st  = st;
         end
      end
      #1;
      chk("R8 intr_o", intr_o, m_intr);
      chk("R5 busy_o", busy_o, m_pend);
      chk("R2 vec_o", vec_o, m_vec);
      chk("R6 status_o", status_o, m_st);
      @(negedge clk);
   endtask

   task automatic drive(input logic v, s, e, d, x, q, input logic [VW-1:0] qv,
                        input logic [SW-1:0] sv, input logic b, i);
      vld = v; sec = s; en = e; dec = d; ext = x; exc = q; evec = qv; st = sv; lb = b; li = i;
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      step(); step();
      // R10 reset state
      chk("R10 intr", intr_o, 0); chk("R10 busy", busy_o, 0);
      chk("R10 vec", vec_o, 0);   chk("R10 status", status_o, 0);
      rst_n = 1;

      // R1/R8 external only -> 0x500 immediately
      drive(1,0,1,0,1,0,'0,16'h1111,0,0); step();
      chk("R1 ext intr", intr_o, 1); chk("R2 ext vec", vec_o, 12'h500);
      // R2 both sources -> timer
      drive(1,0,1,1,1,0,'0,16'h2222,0,0); step();
      chk("R2 dec vec", vec_o, 12'h900); chk("R6 status cap", status_o, 16'h2222);
      // R1 enable off
      drive(1,0,0,1,1,0,'0,16'h3333,0,0); step();
      chk("R1 disabled", intr_o, 0); chk("R1 vec kept", vec_o, 12'h900);
      // R3 no valid instruction
      drive(0,0,1,1,1,0,'0,16'h4444,0,0); step();
      chk("R3 invalid", intr_o, 0);
      // R4 second half
      drive(1,1,1,1,1,0,'0,16'h5555,0,0); step();
      chk("R4 second", intr_o, 0); chk("R4 status kept", status_o, 16'h2222);
      // R9 sync outranks async
      drive(1,0,1,1,1,1,12'h700,16'h6666,0,0); step();
      chk("R9 sync vec", vec_o, 12'h700); chk("R9 intr", intr_o, 1);

      // R5/R6/R11 defer while load/store drains
      drive(1,0,1,0,1,0,'0,16'hAAAA,1,0); step();
      chk("R5 parked busy", busy_o, 1); chk("R5 parked no intr", intr_o, 0);
      drive(1,0,1,1,0,1,12'h123,16'hBBBB,1,0); step();
      chk("R6 vec held", vec_o, 12'h500); chk("R6 status held", status_o, 16'hAAAA);
      chk("R4 pending blocks", busy_o, 1);
      drive(0,0,0,0,0,0,'0,16'hCCCC,0,0); step();
      chk("R11 delivered", intr_o, 1); chk("R11 busy dropped", busy_o, 0);
      chk("R11 vec", vec_o, 12'h500);
      drive(0,0,0,0,0,0,'0,'0,0,0); step();
      chk("R8 single pulse", intr_o, 0);

      // R7 discard on load/store fault
      drive(1,0,1,1,0,0,'0,16'hDDDD,1,0); step();
      chk("R7 parked", busy_o, 1);
      drive(0,0,0,0,0,0,'0,'0,1,1); step();
      chk("R7 busy cleared", busy_o, 0); chk("R7 no intr", intr_o, 0);
      drive(0,0,0,0,0,0,'0,'0,0,0); step();
      chk("R7 stays dropped", intr_o, 0);
      // R7 fault in the detection cycle
      drive(1,0,1,0,1,0,'0,16'hEEEE,0,1); step();
      chk("R7 same-cycle drop", intr_o, 0); chk("R7 same-cycle busy", busy_o, 0);

      // constrained random
      void'($urandom(32'd1234));
      for (int k = 0; k < 4000; k++) begin
         drive(($urandom % 4) != 0, ($urandom % 6) == 0, ($urandom % 3) != 0,
               ($urandom % 5) == 0, ($urandom % 4) == 0, ($urandom % 8) == 0,
               VW'($urandom), SW'($urandom), ($urandom % 3) == 0, ($urandom % 12) == 0);
         if ((k % 997) == 500) rst_n = 0;
         else rst_n = 1;
         step();
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule